// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32768 Hz timebase strobe into a programmable periodic event. A 4-bit rate code picks the period as a power of two of timebase ticks. An enable bit gates the interrupt request. A free-running tick counter is shared by all rates, so events always land on absolute multiples of the selected period, whatever the moment at which the rate or the enable was written.

The surrounding clock logic drives `tick_i` high for one system clock per timebase tick. The register front end supplies the rate code and the enable level. On each event the block raises a one-cycle flag-set pulse and, when enabled, a one-cycle interrupt-request pulse. The status and interrupt latches that consume these pulses sit outside the block. A build parameter selects whether the flag pulse is also produced while the interrupt is disabled.

Top module: `periodic_rate_gen`

## Requirements
- R1: A synchronous active-high reset clears the tick counter and both pulse outputs. While reset is held, no pulse appears even if ticks arrive. After release, the first event with period P falls on the P-th tick.
- R2: Rate code 0 produces no flag pulse and no interrupt pulse for any number of ticks.
- R3: Rate code 1 gives a period of 128 ticks and rate code 2 gives a period of 256 ticks.
- R4: Rate codes 3 to 15 give a period of 2^(code-1) ticks, from 4 ticks (code 3) to 16384 ticks (code 15).
- R5: Events fall on the ticks where the 16-bit count of ticks since reset becomes an exact multiple of the period. The count wraps from 65535 to 0, and that wrap is itself a boundary.
- R6: A rate change takes effect at the next multiple of the new period, counted on the same running count, with no restart of the count.
- R7: Outputs are registered one-cycle pulses, high in the clock cycle after the tick that completes a period. With the default build and the enable low, neither output pulses.
- R8: The interrupt pulse only occurs when the enable is high. With FLAG_WHEN_MASKED=1, the flag pulse continues on every boundary while the enable is low.
- R9: The counter advances only on cycles with `tick_i` high, and no pulse follows a cycle without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe per 32768 Hz timebase tick |
| rate_sel_i | input | RATE_W (4) | Rate code, 0 = off |
| per_en_i | input | 1 | Periodic interrupt enable |
| pf_o | output | 1 | Periodic flag set pulse |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
A corrupted tick count shows up as a pulse displaced from its absolute multiple. This is seen on the next boundary of the active period, which is at most four ticks away at the fastest rate. A wrong code decode shows as the wrong spacing between the first two pulses. The bench compares every tick against a modulo model of the count, so a single early, late or extra pulse is caught in the cycle it happens. A counter that fails to wrap only shows once 65536 ticks have passed, so one run crosses that boundary.

// File: rtl/prg_pkg.sv
`timescale 1ns/1ps
package prg_pkg;

  // Event outputs carried together into the output register.
  typedef struct packed {
    logic pf;
    logic irq;
  } prg_evt_t;

  // Effective boundary bit count for a rate code; codes 1 and 2 fold to 8 and 9.
  function automatic int unsigned rate_shift(input int unsigned code,
                                             input int unsigned limit);
    int unsigned eff;
    eff = (code == 1 || code == 2) ? code + 7 : code;
    if (eff == 0) return 0;
    if (eff - 1 > limit) return limit;
    return eff - 1;
  endfunction

endpackage

// File: rtl/prg_tick_counter.sv
`timescale 1ns/1ps
module prg_tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (rst)         cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_o));

endmodule

// File: rtl/prg_rate_decode.sv
`timescale 1ns/1ps
module prg_rate_decode
  import prg_pkg::*;
#(
  parameter int RATE_W = 4,
  parameter int CNT_W  = 16,
  parameter int SH_W   = 5
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic              active_o,
  output logic [SH_W-1:0]   shift_o
);

  always_comb begin
    active_o = |rate_i;
    shift_o  = SH_W'(rate_shift(32'(rate_i), 32'(CNT_W - 1)));
  end

endmodule

// File: rtl/prg_boundary.sv
`timescale 1ns/1ps
module prg_boundary #(
  parameter int CNT_W = 16,
  parameter int SH_W  = 5
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] nxt;

  // Low 'shift' bits of the count must roll over to zero on a boundary.
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask[i] = (SH_W'(i) < shift_i);
  end

  assign nxt   = cnt_i + 1'b1;
  assign hit_o = tick_i & active_i & ~|(nxt & mask);

endmodule

// File: rtl/periodic_rate_gen.sv
`timescale 1ns/1ps
module periodic_rate_gen
  import prg_pkg::*;
#(
  parameter int CNT_W            = 16,
  parameter int RATE_W           = 4,
  parameter bit FLAG_WHEN_MASKED = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              per_en_i,
  output logic              pf_o,
  output logic              irq_o
);

  localparam int SH_W = $clog2(CNT_W) + 1;

  logic [CNT_W-1:0] cnt;
  logic             active;
  logic [SH_W-1:0]  shift;
  logic             hit;
  logic             flag_qual;
  prg_evt_t         evt_d, evt_q;

  prg_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .tick_i(tick_i),
    .cnt_o (cnt)
  );

  prg_rate_decode #(.RATE_W(RATE_W), .CNT_W(CNT_W), .SH_W(SH_W)) u_dec (
    .rate_i  (rate_sel_i),
    .active_o(active),
    .shift_o (shift)
  );

  prg_boundary #(.CNT_W(CNT_W), .SH_W(SH_W)) u_bnd (
    .cnt_i   (cnt),
    .tick_i  (tick_i),
    .active_i(active),
    .shift_i (shift),
    .hit_o   (hit)
  );

  if (FLAG_WHEN_MASKED) begin : g_flag_free
    assign flag_qual = 1'b1;
  end else begin : g_flag_gated
    assign flag_qual = per_en_i;
    assert_flag_needs_en_R7: assert property (@(posedge clk) disable iff (rst)
      pf_o |-> $past(per_en_i));
  end

  always_comb begin
    evt_d.pf  = hit & flag_qual;
    evt_d.irq = hit & per_en_i;
  end

  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= evt_d;
  end

  assign pf_o  = evt_q.pf;
  assign irq_o = evt_q.irq;

  assert_pulse_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
    pf_o |-> $past(tick_i));

  assert_code0_silent_R2: assert property (@(posedge clk) disable iff (rst)
    pf_o |-> $past(rate_sel_i) != '0);

  assert_irq_enabled_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(per_en_i));

  assert_single_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    pf_o |=> !pf_o);

endmodule

// File: tb/periodic_rate_gen_test.sv
`timescale 1ns/1ps
module periodic_rate_gen_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [3:0] rate = 4'd0;
  logic       en = 1'b0;
  logic       pf, irq, pf_f, irq_f;

  always #10 clk = ~clk;

  periodic_rate_gen uut (
    .clk(clk), .rst(rst), .tick_i(tick), .rate_sel_i(rate),
    .per_en_i(en), .pf_o(pf), .irq_o(irq)
  );

  periodic_rate_gen #(.FLAG_WHEN_MASKED(1'b1)) uut_flag (
    .clk(clk), .rst(rst), .tick_i(tick), .rate_sel_i(rate),
    .per_en_i(en), .pf_o(pf_f), .irq_o(irq_f)
  );

  int checks = 0;
  int fails  = 0;
  int unsigned mcnt = 0;
  int r_pf, r_irq, r_fpf, r_firq, r_bad;

  // code, enable, ticks, expected pf/irq count, expected flag-mode pf count
  localparam int NV = 8;
  localparam int VEC [NV][5] = '{
    '{3, 1,  20, 5, 5},
    '{4, 1,  40, 5, 5},
    '{0, 1,  50, 0, 0},
    '{6, 0, 100, 0, 3},
    '{1, 1, 300, 2, 2},
    '{2, 1, 600, 2, 2},
    '{7, 1, 200, 3, 3},
    '{3, 1,   3, 0, 0}
  };

  function automatic string vec_req(int v);
    case (v)
      2:       return "R2";
      3:       return "R8";
      4, 5:    return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic int unsigned per_of(int code);
    int eff;
    eff = (code == 1) ? 8 : (code == 2) ? 9 : code;
    return 1 << (eff - 1);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mcnt = 0;
  endtask

  // Called at a negedge; one tick per cycle, or tick/idle alternating when gap is set.
  task automatic run(int n, bit gap);
    bit hit;
    int unsigned nxt;
    r_pf = 0; r_irq = 0; r_fpf = 0; r_firq = 0; r_bad = 0;
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      nxt = (mcnt + 1) % 65536;
      hit = (rate != 0) && (nxt % per_of(int'(rate)) == 0);
      if (pf    !== (hit && en)) r_bad++;
      if (irq   !== (hit && en)) r_bad++;
      if (pf_f  !== hit)         r_bad++;
      if (irq_f !== (hit && en)) r_bad++;
      r_pf   += int'(pf);
      r_irq  += int'(irq);
      r_fpf  += int'(pf_f);
      r_firq += int'(irq_f);
      mcnt = nxt;
      if (gap) begin
        tick = 1'b0;
        @(posedge clk);
        @(negedge clk);
        if (pf | irq | pf_f | irq_f) r_bad++;
      end
    end
    tick = 1'b0;
  endtask

  initial begin
    #(20 * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: ticks during reset produce nothing
    @(negedge clk);
    rst = 1'b1; rate = 4'd3; en = 1'b1; tick = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!(pf | irq | pf_f | irq_f), "R1", "outputs in reset",
            int'(pf | irq | pf_f | irq_f), 0);
    end
    tick = 1'b0; rst = 1'b0; mcnt = 0;
    run(4, 1'b0);
    check(r_bad == 0, "R1", "first event on 4th tick, mismatches", r_bad, 0);
    check(r_pf == 1, "R1", "pulses after release", r_pf, 1);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      rate = 4'(VEC[v][0]);
      en   = VEC[v][1][0];
      run(VEC[v][2], 1'b0);
      check(r_bad == 0, vec_req(v), "per-tick mismatches", r_bad, 0);
      check(r_pf == VEC[v][3], vec_req(v), "pf count", r_pf, VEC[v][3]);
      check(r_irq == VEC[v][3], vec_req(v), "irq count", r_irq, VEC[v][3]);
      check(r_fpf == VEC[v][4], vec_req(v), "flag-mode pf count", r_fpf, VEC[v][4]);
      check(r_firq == VEC[v][3], vec_req(v), "flag-mode irq count", r_firq, VEC[v][3]);
    end

    // R6: switch from period 32 to period 4 at count 10; events at 12 and 16
    do_reset();
    rate = 4'd6; en = 1'b1;
    run(10, 1'b0);
    check(r_pf == 0, "R6", "pulses before switch", r_pf, 0);
    rate = 4'd3;
    run(6, 1'b0);
    check(r_bad == 0, "R6", "mismatches after switch", r_bad, 0);
    check(r_pf == 2, "R6", "pulses after switch", r_pf, 2);

    // R7 / R8: enable dropped mid-run
    do_reset();
    rate = 4'd3; en = 1'b1;
    run(8, 1'b0);
    check(r_irq == 2, "R8", "irq with enable", r_irq, 2);
    en = 1'b0;
    run(8, 1'b0);
    check(r_pf == 0, "R7", "default pf with enable low", r_pf, 0);
    check(r_irq == 0, "R8", "irq with enable low", r_irq, 0);
    check(r_fpf == 2, "R8", "flag-mode pf with enable low", r_fpf, 2);
    check(r_firq == 0, "R8", "flag-mode irq with enable low", r_firq, 0);

    // R9: idle cycles between ticks
    do_reset();
    rate = 4'd3; en = 1'b1;
    run(12, 1'b1);
    check(r_bad == 0, "R9", "mismatches with idle cycles", r_bad, 0);
    check(r_pf == 3, "R9", "pulses over 12 spaced ticks", r_pf, 3);

    // R5: full wrap at the slowest rate, then period 4 from the wrapped count
    do_reset();
    rate = 4'd15; en = 1'b1;
    run(65536, 1'b0);
    check(r_bad == 0, "R5", "mismatches across wrap", r_bad, 0);
    check(r_pf == 4, "R5", "events in 65536 ticks", r_pf, 4);
    rate = 4'd3;
    run(4, 1'b0);
    check(r_bad == 0, "R5", "mismatches after wrap", r_bad, 0);
    check(r_pf == 1, "R5", "event at count 4 after wrap", r_pf, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule